// File: doc/BRIEF.md
# Receive Character Option Filter

This block sits between a serial receiver and the receive buffer of one channel and applies the channel's receive options to every character on its way through. Each character arrives with a strobe, eight data bits, an error flag for parity or framing errors, and a flag that marks an all-zero break frame. The block can clear the top data bit. It can treat one programmable character as a literal-next escape that makes the following character plain data. It compares characters against a programmable special character, and that comparison can include or leave out errored characters. It also reports the start of a line break and, on request, the end of that break as a separate one-clock event.

Three small registers are written and read through a simple select/data port: the option register, the special-character register and the literal-next register. All results come out one clock after the input strobe. A downstream buffer takes a character whenever the output strobe is high.

Top module: `rx_char_filter`

## Requirements
- R1: When option bit 0 (strip) is 1, output data bit 7 is 0 for every character passed through; when it is 0, data passes unchanged.
- R2: Stripping is applied before any comparison, so with strip set an input of 0x80 plus the low seven bits of the special or literal-next register matches that register.
- R3: With option bit 1 (literal-next enable) set, a qualified non-break character equal to the literal-next register is consumed with no output strobe. The next received character of any kind clears the pending escape. If that next character is not a break frame, it is output with the special flag at 0, even when it equals the literal-next or special value.
- R4: With option bit 2 (match on error) set, errored characters are compared against the special register and the literal-next register. With it clear, only characters received without error are compared.
- R5: Every character that is output carries its input error flag on the error output, whatever the option settings.
- R6: The first break frame after a non-break state gives a one-clock break-start pulse. Break frames are never output as data, and further break frames give no more start pulses.
- R7: While in a break, the first non-break character or idle-line tick ends the break. If option bit 3 (end-of-break detect) is set, that event gives a one-clock break-end pulse. An ending character is processed normally in the same cycle.
- R8: After reset all three registers read 0x00. The register select is 0 for options, 1 for the special character, 2 for literal-next, and 3 reads 0x00. Option bits 7:4 always read 0.
- R9: The data, special, error and event outputs change on the clock edge that samples the input strobe, one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select (0 options, 1 special, 2 literal-next) |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data for the selected register |
| rx_valid | input | 1 | Received character strobe |
| rx_data | input | 8 | Received character |
| rx_err | input | 1 | Parity or framing error on this character |
| rx_brk | input | 1 | This character is an all-zero break frame |
| idle_tick | input | 1 | Line sampled idle (marking) |
| out_valid | output | 1 | Filtered character strobe |
| out_data | output | 8 | Filtered character |
| out_special | output | 1 | Character matched the special register |
| out_err | output | 1 | Character was received with an error |
| brk_start | output | 1 | One-clock pulse at the start of a break |
| brk_end | output | 1 | One-clock pulse at the end of a break |

## Verification
The bench targets an escape followed by a second literal-next character. A design that re-arms the escape there would swallow that character. It checks that a break frame or an errored character arriving while an escape is pending still clears the escape, which a design that clears only on good data would miss. It drives characters with bit 7 set whose low bits match the special value, which catches comparison before stripping. It ends breaks both by an idle tick and by a character, with end-of-break detection on and off, and writes 0xFF to the option register to show the unused bits reading back as zero.

// File: rtl/rx_char_filter.sv
module rx_char_filter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [1:0]    cfg_sel,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cfg_rdata,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_err,
  input  logic          rx_brk,
  input  logic          idle_tick,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          out_special,
  output logic          out_err,
  output logic          brk_start,
  output logic          brk_end
);

  localparam int OPT_W = 4;

  logic [OPT_W-1:0] opt_q;
  logic [DW-1:0]    spc_q, lnc_q;
  logic             pend_q, in_brk_q;

  wire opt_strip = opt_q[0];
  wire opt_lne   = opt_q[1];
  wire opt_moe   = opt_q[2];
  wire opt_eob   = opt_q[3];

  wire [DW-1:0] sd   = opt_strip ? {1'b0, rx_data[DW-2:0]} : rx_data;
  wire          qual = !rx_err || opt_moe;
  wire          good = rx_valid && !rx_brk;
  wire          esc  = good && !pend_q && opt_lne && qual && (sd == lnc_q);
  wire          ends = in_brk_q && (good || (!rx_valid && idle_tick));

  always_comb begin
    case (cfg_sel)
      2'd0:    cfg_rdata = {{(DW-OPT_W){1'b0}}, opt_q};
      2'd1:    cfg_rdata = spc_q;
      2'd2:    cfg_rdata = lnc_q;
      default: cfg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      opt_q <= '0;
      spc_q <= '0;
      lnc_q <= '0;
    end else if (cfg_wr) begin
      case (cfg_sel)
        2'd0:    opt_q <= cfg_wdata[OPT_W-1:0];
        2'd1:    spc_q <= cfg_wdata;
        2'd2:    lnc_q <= cfg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q      <= 1'b0;
      in_brk_q    <= 1'b0;
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_special <= 1'b0;
      out_err     <= 1'b0;
      brk_start   <= 1'b0;
      brk_end     <= 1'b0;
    end else begin
      out_valid   <= good && !esc;
      out_special <= good && !esc && !pend_q && qual && (sd == spc_q);
      brk_start   <= rx_valid && rx_brk && !in_brk_q;
      brk_end     <= ends && opt_eob;
      if (rx_valid) begin
        out_data <= sd;
        out_err  <= rx_err;
        pend_q   <= esc;
      end
      if (rx_valid && rx_brk) in_brk_q <= 1'b1;
      else if (ends)          in_brk_q <= 1'b0;
    end
  end

  p_strip_bit7_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && opt_strip) |=> !out_data[DW-1]);

  p_escaped_plain_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && pend_q) |=> (!out_special && !pend_q));

  p_err_unmatched_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_err && !opt_moe) |=> !out_special);

  p_brk_not_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_brk) |=> !out_valid);

  p_eob_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    brk_end |=> !brk_end);

  p_events_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(brk_start && brk_end));

  p_opt_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_sel == 2'd0) |-> (cfg_rdata[DW-1:OPT_W] == '0));

endmodule

// File: tb/rx_char_filter_tb.sv
module rx_char_filter_tb;
  logic clk = 0, rst_n = 0;
  logic cfg_wr = 0; logic [1:0] cfg_sel = 0; logic [7:0] cfg_wdata = 0, cfg_rdata;
  logic rx_valid = 0, rx_err = 0, rx_brk = 0, idle_tick = 0; logic [7:0] rx_data = 0;
  logic out_valid, out_special, out_err, brk_start, brk_end; logic [7:0] out_data;

  int errs = 0, checks = 0;
  bit done = 0;
  logic [3:0] m_opt; logic [7:0] m_spc, m_lnc; bit m_pend, m_brk;
  bit e_valid, e_spec, e_err, e_start, e_end; logic [7:0] e_data;

  always #2 clk = ~clk;

  rx_char_filter u_dut (.clk, .rst_n, .cfg_wr, .cfg_sel, .cfg_wdata, .cfg_rdata,
    .rx_valid, .rx_data, .rx_err, .rx_brk, .idle_tick,
    .out_valid, .out_data, .out_special, .out_err, .brk_start, .brk_end);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] strip_fn(logic [7:0] d, logic s);
    return s ? {1'b0, d[6:0]} : d;
  endfunction

  task automatic wr(logic [1:0] s, logic [7:0] v);
    cfg_wr = 1; cfg_sel = s; cfg_wdata = v;
    @(posedge clk); #1;
    cfg_wr = 0; cfg_sel = 0;
    case (s) 2'd0: m_opt = v[3:0]; 2'd1: m_spc = v; 2'd2: m_lnc = v; default: ; endcase
  endtask

  task automatic step(bit v, logic [7:0] d, bit e, bit b, bit idl);
    logic [7:0] sd; bit q;
    rx_valid = v; rx_data = d; rx_err = e; rx_brk = b; idle_tick = idl;
    sd = strip_fn(d, m_opt[0]); q = !e || m_opt[2];
    e_valid = 0; e_spec = 0; e_start = 0; e_end = 0; e_data = sd; e_err = e;
    if (v && b) begin
      e_start = !m_brk; m_brk = 1; m_pend = 0;
    end else if (v) begin
      if (m_brk) begin e_end = m_opt[3]; m_brk = 0; end
      if (m_pend) begin e_valid = 1; m_pend = 0; end
      else if (m_opt[1] && q && sd == m_lnc) m_pend = 1;
      else begin e_valid = 1; e_spec = q && (sd == m_spc); end
    end else if (idl && m_brk) begin
      e_end = m_opt[3]; m_brk = 0;
    end
    @(posedge clk); #1;
    rx_valid = 0; idle_tick = 0;
    chk("R9 out_valid", out_valid, e_valid);
    chk("R6 brk_start", brk_start, e_start);
    chk("R7 brk_end", brk_end, e_end);
    if (e_valid) begin
      chk("R1/R2 out_data", out_data, e_data);
      chk("R3/R4 out_special", out_special, e_spec);
      chk("R5 out_err", out_err, e_err);
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    m_opt = 0; m_spc = 0; m_lnc = 0; m_pend = 0; m_brk = 0;
    repeat (3) @(posedge clk); #1; rst_n = 1;
    // R8 reset state
    chk("R8 out_valid reset", out_valid, 0);
    for (int s = 0; s < 4; s++) begin
      cfg_sel = s[1:0]; #1; chk("R8 reset readback", cfg_rdata, 8'h00);
    end
    wr(0, 8'hFF); cfg_sel = 0; #1; chk("R8 option upper bits", cfg_rdata, 8'h0F);
    cfg_sel = 3; #1; chk("R8 select 3", cfg_rdata, 8'h00);
    wr(1, 8'h13); wr(2, 8'h16); cfg_sel = 1; #1; chk("R8 special readback", cfg_rdata, 8'h13);
    // R1/R2 strip then compare
    wr(0, 8'h01);
    step(1, 8'h93, 0, 0, 0); chk("R2 stripped match", out_special, 1);
    wr(0, 8'h00);
    step(1, 8'h93, 0, 0, 0); chk("R1 no strip keeps bit7", out_data, 8'h93);
    // R3 escape, double literal-next
    wr(0, 8'h02);
    step(1, 8'h16, 0, 0, 0); chk("R3 escape consumed", out_valid, 0);
    step(1, 8'h16, 0, 0, 0); chk("R3 escaped lnext output", out_valid, 1);
    step(1, 8'h16, 0, 0, 0);
    step(1, 8'h13, 0, 0, 0); chk("R3 escaped special plain", out_special, 0);
    step(1, 8'h13, 0, 0, 0); chk("R3 pending cleared", out_special, 1);
    step(1, 8'h16, 0, 0, 0); step(1, 8'h00, 1, 1, 0);
    step(1, 8'h13, 0, 0, 0); chk("R3 break clears escape", out_special, 1);
    // R4/R5 match on error
    step(1, 8'h13, 1, 0, 0); chk("R4 error not matched", out_special, 0);
    chk("R5 error flag", out_err, 1);
    wr(0, 8'h04);
    step(1, 8'h13, 1, 0, 0); chk("R4 error matched", out_special, 1);
    // R6/R7 breaks
    wr(0, 8'h08);
    step(1, 8'h00, 1, 1, 0); chk("R6 start pulse", brk_start, 1);
    step(1, 8'h00, 1, 1, 0); chk("R6 no repeat start", brk_start, 0);
    step(0, 8'h00, 0, 0, 1); chk("R7 idle ends break", brk_end, 1);
    step(0, 8'h00, 0, 0, 0); chk("R7 single pulse", brk_end, 0);
    step(1, 8'h00, 1, 1, 0);
    step(1, 8'h41, 0, 0, 0); chk("R7 char ends break", brk_end, 1);
    chk("R7 ending char output", out_data, 8'h41);
    wr(0, 8'h00);
    step(1, 8'h00, 1, 1, 0); step(0, 8'h00, 0, 0, 1); chk("R7 no end when disabled", brk_end, 0);
    // random mix
    void'($urandom(32'd1284));
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] d; int r;
      if ($urandom_range(0, 99) < 3) wr(0, 8'($urandom_range(0, 255)));
      r = $urandom_range(0, 4);
      d = (r == 0) ? 8'h13 : (r == 1) ? 8'h93 : (r == 2) ? 8'h16 : (r == 3) ? 8'h96 : 8'($urandom_range(0, 255));
      if ($urandom_range(0, 9) < 7) begin
        if ($urandom_range(0, 9) == 0) step(1, 8'h00, 1, 1, 0);
        else step(1, d, $urandom_range(0, 4) == 0, 0, 0);
      end else step(0, d, 0, 0, $urandom_range(0, 2) == 0);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule